// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block moves data between memory and one fixed peripheral address on behalf of a CPU, one transfer per request. Software programs a memory address, a transfer count and an 8-bit control register, then arms the channel. Each rising edge on the selected request line starts one transfer. A transfer is a single read bus cycle at the current memory address, followed by a single write bus cycle that carries the read data to the peripheral address. After each transfer the memory address steps up or down and the count drops by one.

In single-run mode the channel switches itself off after the last transfer and can interrupt the CPU. In repeat mode it reloads its starting address and count and stays on. The enable bit guards against stray writes: a write of 1 takes effect only if software first read the control register while the channel was off. A standby input returns the control register to zero.

Top module: `xfer_channel`

## Requirements
- R1: After reset the control register reads 0x00, the interrupt output is 0, and neither bus strobe is active.
- R2: A cycle with standby high returns the control register to 0x00 and drops the interrupt output.
- R3: The control register sits at register select 0 with this layout: bit 7 enable, bit 6 word size, bit 5 address decrement, bit 4 repeat, bit 3 interrupt enable, bits 2:0 request source. Bits 6..0 take any written value. A written 1 in bit 7 sets enable only if a control read (cpu_rd at select 0) occurred while enable was 0 and no control write came between that read and this write. Otherwise enable stays 0.
- R4: While enable is 0, request edges start no bus cycle and leave the address and count unchanged.
- R5: A rising edge on the selected request line, with enable set and the channel idle, gives bus_rd for one cycle on the next clock. bus_wr to IO_ADDR follows for one cycle and carries the read data. bus_word shows the size bit during the read.
- R6: The memory address (select 1) steps by 1 for byte transfers and by 2 for word transfers, up when bit 5 is 0 and down when it is 1. For word transfers, bit 0 of bus_addr is driven 0.
- R7: The count (select 2) drops by one per transfer. In single-run mode, enable clears at the end of the transfer that brings the count from 1 to 0.
- R8: When enable falls from 1 to 0 with interrupt enable set, irq goes to 1. It stays at 1 until a control write with bit 7 set, or until interrupt enable reads 0.
- R9: A write to select 1 or 2 also loads a shadow copy. In repeat mode, the transfer that would bring the count to 0 instead reloads address and count from the shadows, and enable stays 1.
- R10: Source codes at or above NREQ (4..7 by default) never start a transfer. Only the request line whose index equals the source code can start one.
- R11: Each rising edge starts at most one transfer. A request held high gives a single transfer, and an edge that arrives while a transfer is in progress is dropped.
- R12: Byte transfers pass only bits 7:0 of the read data, with the upper write-data bits at 0. Word transfers pass all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Clears control register and interrupt |
| cpu_sel | input | 2 | Register select: 0 control, 1 address, 2 count |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data for the current select |
| req_in | input | NREQ | Transfer request lines |
| bus_addr | output | AW | Bus cycle address |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_word | output | 1 | Word-size bus cycle |
| bus_rdata | input | DW | Data returned by a read cycle |
| bus_wdata | output | DW | Data for a write cycle |
| irq | output | 1 | CPU interrupt request |

## Verification
Assertions check on every cycle that standby clears the register, that an enable write without arming is refused, that a falling enable with interrupt enable set raises irq, and that read and write strobes come in order. They also check that word cycles use even addresses and that an idle, disabled channel stays idle. The data path cannot be checked by a property, so only the bench scenarios show it. The bench covers address stepping in all four size and direction combinations, the count reaching zero, reload in repeat mode, the source decoding sweep, and the drop of held or mid-transfer request edges.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } eng_state_t;

   // Bit order of the control register, bit 7 first.
   typedef struct packed {
      logic       en;
      logic       word;
      logic       dec;
      logic       rpt;
      logic       ie;
      logic [2:0] src;
   } chan_ctl_t;

   localparam logic [1:0] SEL_CTL = 2'd0;
   localparam logic [1:0] SEL_ADR = 2'd1;
   localparam logic [1:0] SEL_CNT = 2'd2;

   localparam int unsigned SRC_CODES = 8;

endpackage

// File: rtl/dmx_ctl_reg.sv
module dmx_ctl_reg
   import dmx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      standby,
   input  logic      wr_ctl,
   input  logic      rd_ctl,
   input  logic [7:0] wdata,
   input  logic      done_clr,
   output chan_ctl_t ctl,
   output logic      irq
);

   chan_ctl_t ctl_q, ctl_d, wv;
   logic      arm_q;
   logic      irq_q;

   always_comb begin
      wv    = chan_ctl_t'(wdata);
      ctl_d = ctl_q;
      if (wr_ctl) begin
         ctl_d    = wv;
         ctl_d.en = wv.en & (ctl_q.en | arm_q);
      end
      if (done_clr) ctl_d.en = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         arm_q <= 1'b0;
         irq_q <= 1'b0;
      end else if (standby) begin
         ctl_q <= '0;
         arm_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         ctl_q <= ctl_d;
         if (wr_ctl)
            arm_q <= 1'b0;
         else if (rd_ctl && !ctl_q.en)
            arm_q <= 1'b1;
         if (ctl_q.en && !ctl_d.en && ctl_d.ie)
            irq_q <= 1'b1;
         else if ((wr_ctl && wv.en) || !ctl_d.ie)
            irq_q <= 1'b0;
      end
   end

   assign ctl = ctl_q;
   assign irq = irq_q;

   AST_STANDBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (ctl_q == '0) && !irq_q); // R2

   AST_ARM_REQUIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !standby && wv.en && !ctl_q.en && !arm_q) |=> !ctl_q.en); // R3

   AST_IRQ_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q.en && $past(ctl_q.en) && ctl_q.ie) |-> irq_q); // R8

endmodule

// File: rtl/dmx_req_gate.sv
module dmx_req_gate
   import dmx_pkg::*;
#(
   parameter int unsigned NREQ = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            standby,
   input  logic [NREQ-1:0] req_in,
   input  logic [2:0]      src,
   input  logic            en,
   input  logic            idle,
   output logic            start
);

   logic [SRC_CODES-1:0] code_map;
   logic                 sel_req;
   logic                 prev_q;

   for (genvar g = 0; g < SRC_CODES; g++) begin : g_map
      if (g < NREQ) begin : g_wired
         assign code_map[g] = req_in[g];
      end else begin : g_open
         assign code_map[g] = 1'b0;
      end
   end

   assign sel_req = code_map[src];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_q <= 1'b0;
      else if (standby) prev_q <= 1'b0;
      else              prev_q <= sel_req;
   end

   assign start = en && idle && sel_req && !prev_q;

   AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start); // R11

endmodule

// File: rtl/dmx_engine.sv
module dmx_engine
   import dmx_pkg::*;
#(
   parameter int unsigned   AW      = 16,
   parameter int unsigned   DW      = 16,
   parameter int unsigned   CW      = 16,
   parameter logic [AW-1:0] IO_ADDR = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          standby,
   input  logic          start,
   input  logic          word,
   input  logic          dec,
   input  logic          rpt,
   input  logic          wr_adr,
   input  logic          wr_cnt,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] bus_rdata,
   output logic [AW-1:0] mar,
   output logic [CW-1:0] cnt,
   output logic [AW-1:0] bus_addr,
   output logic          bus_rd,
   output logic          bus_wr,
   output logic          bus_word,
   output logic [DW-1:0] bus_wdata,
   output logic          idle,
   output logic          done_clr
);

   localparam int unsigned BYTE_W = 8;

   eng_state_t    state_q;
   logic [AW-1:0] mar_q, mar_sh, mar_step, step;
   logic [CW-1:0] cnt_q, cnt_sh;
   logic [DW-1:0] dbuf_q;
   logic          last;

   assign step     = word ? AW'(2) : AW'(1);
   assign mar_step = dec ? (mar_q - step) : (mar_q + step);
   assign last     = (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mar_q   <= '0;
         mar_sh  <= '0;
         cnt_q   <= '0;
         cnt_sh  <= '0;
         dbuf_q  <= '0;
      end else if (standby) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (start) state_q <= ST_RD;
            ST_RD: begin
               dbuf_q  <= word ? bus_rdata
                               : {{(DW-BYTE_W){1'b0}}, bus_rdata[BYTE_W-1:0]};
               state_q <= ST_WR;
            end
            ST_WR: begin
               state_q <= ST_IDLE;
               if (last && rpt) begin
                  mar_q <= mar_sh;
                  cnt_q <= cnt_sh;
               end else begin
                  mar_q <= mar_step;
                  cnt_q <= cnt_q - CW'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
         if (wr_adr) begin
            mar_q  <= wdata[AW-1:0];
            mar_sh <= wdata[AW-1:0];
         end
         if (wr_cnt) begin
            cnt_q  <= wdata[CW-1:0];
            cnt_sh <= wdata[CW-1:0];
         end
      end
   end

   always_comb begin
      bus_rd   = (state_q == ST_RD);
      bus_wr   = (state_q == ST_WR);
      bus_word = bus_rd && word;
      if (bus_wr)
         bus_addr = IO_ADDR;
      else if (bus_rd && word)
         bus_addr = {mar_q[AW-1:1], 1'b0};
      else if (bus_rd)
         bus_addr = mar_q;
      else
         bus_addr = '0;
   end

   assign bus_wdata = bus_wr ? dbuf_q : '0;
   assign mar       = mar_q;
   assign cnt       = cnt_q;
   assign idle      = (state_q == ST_IDLE);
   assign done_clr  = (state_q == ST_WR) && last && !rpt && !standby;

   AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !standby) |=> bus_wr); // R5

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr)); // R5

   AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_word) |-> !bus_addr[0]); // R6

endmodule

// File: rtl/xfer_channel.sv
module xfer_channel
   import dmx_pkg::*;
#(
   parameter int unsigned   AW      = 16,
   parameter int unsigned   DW      = 16,
   parameter int unsigned   CW      = 16,
   parameter int unsigned   NREQ    = 4,
   parameter logic [AW-1:0] IO_ADDR = 16'hFF00
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            standby,
   input  logic [1:0]      cpu_sel,
   input  logic            cpu_rd,
   input  logic            cpu_wr,
   input  logic [DW-1:0]   cpu_wdata,
   output logic [DW-1:0]   cpu_rdata,
   input  logic [NREQ-1:0] req_in,
   output logic [AW-1:0]   bus_addr,
   output logic            bus_rd,
   output logic            bus_wr,
   output logic            bus_word,
   input  logic [DW-1:0]   bus_rdata,
   output logic [DW-1:0]   bus_wdata,
   output logic            irq
);

   if (DW != 16) begin : g_chk_dw
      $error("xfer_channel: DW must be 16");
   end
   if (AW < 2 || AW > DW) begin : g_chk_aw
      $error("xfer_channel: AW must lie in 2..DW");
   end
   if (CW < 1 || CW > DW) begin : g_chk_cw
      $error("xfer_channel: CW must lie in 1..DW");
   end
   if (NREQ < 1 || NREQ > SRC_CODES) begin : g_chk_nreq
      $error("xfer_channel: NREQ must lie in 1..8");
   end

   chan_ctl_t     ctl;
   logic          start, idle, done_clr;
   logic [AW-1:0] mar;
   logic [CW-1:0] cnt;
   logic          wr_ctl, rd_ctl, wr_adr, wr_cnt;

   assign wr_ctl = cpu_wr && (cpu_sel == SEL_CTL);
   assign rd_ctl = cpu_rd && (cpu_sel == SEL_CTL);
   assign wr_adr = cpu_wr && (cpu_sel == SEL_ADR);
   assign wr_cnt = cpu_wr && (cpu_sel == SEL_CNT);

   dmx_ctl_reg u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .standby  (standby),
      .wr_ctl   (wr_ctl),
      .rd_ctl   (rd_ctl),
      .wdata    (cpu_wdata[7:0]),
      .done_clr (done_clr),
      .ctl      (ctl),
      .irq      (irq)
   );

   dmx_req_gate #(.NREQ(NREQ)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .standby (standby),
      .req_in  (req_in),
      .src     (ctl.src),
      .en      (ctl.en),
      .idle    (idle),
      .start   (start)
   );

   dmx_engine #(.AW(AW), .DW(DW), .CW(CW), .IO_ADDR(IO_ADDR)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby   (standby),
      .start     (start),
      .word      (ctl.word),
      .dec       (ctl.dec),
      .rpt       (ctl.rpt),
      .wr_adr    (wr_adr),
      .wr_cnt    (wr_cnt),
      .wdata     (cpu_wdata),
      .bus_rdata (bus_rdata),
      .mar       (mar),
      .cnt       (cnt),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_word  (bus_word),
      .bus_wdata (bus_wdata),
      .idle      (idle),
      .done_clr  (done_clr)
   );

   always_comb begin
      case (cpu_sel)
         SEL_CTL: cpu_rdata = DW'(ctl);
         SEL_ADR: cpu_rdata = DW'(mar);
         SEL_CNT: cpu_rdata = DW'(cnt);
         default: cpu_rdata = '0;
      endcase
   end

   AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.en && idle) |=> idle); // R4

endmodule

// File: tb/sim_xfer_channel.sv
module sim_xfer_channel;
   localparam int unsigned AW = 16, DW = 16, CW = 16, NREQ = 4;
   localparam logic [15:0] IOA  = 16'hFF00;
   localparam logic [15:0] PATT = 16'h5A3C;

   logic            clk = 1'b0, rst_n = 1'b0, standby = 1'b0;
   logic [1:0]      cpu_sel = 2'd0;
   logic            cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [DW-1:0]   cpu_wdata = '0, cpu_rdata;
   logic [NREQ-1:0] req_in = '0;
   logic [AW-1:0]   bus_addr;
   logic            bus_rd, bus_wr, bus_word, irq;
   logic [DW-1:0]   bus_rdata, bus_wdata;

   int errs = 0, checks = 0;
   bit done = 1'b0;

   xfer_channel #(.AW(AW), .DW(DW), .CW(CW), .NREQ(NREQ), .IO_ADDR(IOA)) u0 (
      .clk(clk), .rst_n(rst_n), .standby(standby), .cpu_sel(cpu_sel),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .req_in(req_in), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
      .bus_rdata(bus_rdata), .bus_wdata(bus_wdata), .irq(irq));

   always #10 clk = ~clk;

   assign bus_rdata = bus_addr ^ PATT;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk); cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk); cpu_wr = 1'b0;
   endtask

   task automatic arm();
      @(negedge clk); cpu_sel = 2'd0; cpu_rd = 1'b1;
      @(negedge clk); cpu_rd = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [15:0] v);
      @(negedge clk); cpu_sel = s; #1; v = cpu_rdata;
   endtask

   task automatic xfer(input int line, input logic [15:0] a, input bit word);
      logic [15:0] ea;
      ea = word ? (a & 16'hFFFE) : a;
      @(negedge clk); req_in[line] = 1'b1;
      @(negedge clk); req_in[line] = 1'b0;
      chk("R5 read strobe", bus_rd, 1);
      chk("R6 read address", bus_addr, ea);
      chk("R5 size on bus", bus_word, word);
      @(negedge clk);
      chk("R5 write strobe", bus_wr, 1);
      chk("R5 peripheral address", bus_addr, IOA);
      chk("R12 write data", bus_wdata, word ? (ea ^ PATT) : {8'h00, ea[7:0] ^ PATT[7:0]});
      @(negedge clk);
   endtask

   task automatic quiet(input logic [NREQ-1:0] mask, input string tag);
      @(negedge clk); req_in = mask;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(tag, {bus_rd, bus_wr}, 2'b00);
      end
      req_in = '0;
   endtask

   initial begin
      logic [15:0] v, a, cv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(2'd0, v); chk("R1 control at reset", v, 16'h0000);
      chk("R1 irq at reset", irq, 0);
      chk("R1 no strobes at reset", {bus_rd, bus_wr}, 2'b00);

      // R3 enable refused without arming read; other bits written
      wr(2'd0, 16'h008B); rd(2'd0, v); chk("R3 unarmed enable refused", v, 16'h000B);
      arm(); wr(2'd0, 16'h0000); wr(2'd0, 16'h0080);
      rd(2'd0, v); chk("R3 arm lost after write", v, 16'h0000);

      // R4 disabled channel ignores requests
      wr(2'd1, 16'h0040); wr(2'd2, 16'd5);
      quiet(4'b0001, "R4 no cycle while disabled");
      rd(2'd2, v); chk("R4 count unchanged", v, 16'd5);
      rd(2'd1, v); chk("R4 address unchanged", v, 16'h0040);

      // Sweep: size x direction x source, three transfers each
      for (int cfg = 0; cfg < 4; cfg++) begin
         for (int s = 0; s < NREQ; s++) begin
            bit w, d;
            logic [7:0] cw;
            w = cfg[1]; d = cfg[0];
            a = 16'h0200 + 16'(cfg * 16'h40) + 16'(s);
            cw = {1'b1, w, d, 1'b0, 1'b1, 3'(s)};
            wr(2'd1, a); wr(2'd2, 16'd3);
            arm(); wr(2'd0, {8'h00, cw});
            rd(2'd0, v); chk("R3 armed enable takes", v, {8'h00, cw});
            chk("R8 irq cleared by enable write", irq, 0);
            for (int t = 0; t < 3; t++) begin
               xfer(s, a, w);
               a = d ? a - (w ? 16'd2 : 16'd1) : a + (w ? 16'd2 : 16'd1);
               rd(2'd1, v); chk("R6 address step", v, a);
               rd(2'd2, v); chk("R7 count step", v, 16'(2 - t));
            end
            rd(2'd0, v); chk("R7 enable cleared at end", v, {8'h00, cw & 8'h7F});
            chk("R8 irq on end of run", irq, 1);
         end
      end

      // R8 irq held until ie cleared
      wr(2'd0, 16'h0008);
      chk("R8 irq held", irq, 1);
      wr(2'd0, 16'h0000);
      chk("R8 irq dropped with ie", irq, 0);
      // R8 CPU disable also interrupts
      arm(); wr(2'd0, 16'h0088); wr(2'd0, 16'h0008);
      chk("R8 irq on CPU disable", irq, 1);

      // R10 unwired codes and non-selected lines
      wr(2'd2, 16'd4); arm(); wr(2'd0, 16'h008D);
      quiet(4'b1111, "R10 unwired code starts nothing");
      arm(); wr(2'd0, 16'h0081); wr(2'd0, 16'h0081);
      quiet(4'b1101, "R10 other lines ignored");
      rd(2'd2, v); chk("R10 count unchanged", v, 16'd4);

      // R11 held request and edge during busy
      wr(2'd1, 16'h0500); wr(2'd2, 16'd5); arm(); wr(2'd0, 16'h0080);
      @(negedge clk); req_in[0] = 1'b1;
      repeat (10) @(negedge clk);
      req_in[0] = 1'b0;
      rd(2'd2, cv); chk("R11 held request one transfer", cv, 16'd4);
      @(negedge clk); req_in[0] = 1'b1;
      @(negedge clk); req_in[0] = 1'b0;
      @(negedge clk); req_in[0] = 1'b1;
      repeat (6) @(negedge clk);
      req_in[0] = 1'b0;
      rd(2'd2, cv); chk("R11 busy edge dropped", cv, 16'd3);

      // R9 repeat mode reload
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h0300); wr(2'd2, 16'd2); arm(); wr(2'd0, 16'h0098);
      xfer(0, 16'h0300, 1'b0);
      xfer(0, 16'h0301, 1'b0);
      rd(2'd1, v); chk("R9 address reloaded", v, 16'h0300);
      rd(2'd2, v); chk("R9 count reloaded", v, 16'd2);
      rd(2'd0, v); chk("R9 enable kept", v, 16'h0098);
      chk("R9 no irq in repeat", irq, 0);
      xfer(0, 16'h0300, 1'b0);

      // R6 word at odd address
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'h0701); wr(2'd2, 16'd2); arm(); wr(2'd0, 16'h00C0);
      xfer(0, 16'h0701, 1'b1);
      rd(2'd1, v); chk("R6 odd word step", v, 16'h0703);

      // R2 standby clears
      wr(2'd0, 16'h00C8);
      @(negedge clk); standby = 1'b1;
      @(negedge clk); standby = 1'b0;
      rd(2'd0, v); chk("R2 control cleared by standby", v, 16'h0000);
      chk("R2 irq cleared by standby", irq, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule